// File: doc/BRIEF.md
# Transport-Stream Output Clock Mode Generator

This block makes the output clock for a transport-stream output port. It runs in the domain of a fast reference clock. Its output is a registered clock level, `oclk_o`, together with a single-cycle enable that marks each rising edge of that level. Two control bits choose where the output clock comes from. One choice toggles on strobes from the recovered symbol rate, and only while symbol lock is present. A second choice, kept for test work, toggles on strobes from a decimation-ratio timer. A third is an integer divider of the reference clock, with a divisor equal to a small programmed field plus a fixed offset of six. The fourth follows an external clock pin after that pin has been synchronized.

A new mode or ratio is not used at once. The block keeps an active copy of the configuration and reloads it only on the edge where the generated clock falls. A half period that is already running always completes, so a configuration write cannot cut a pulse short. There is one exception. While the symbol-rate source is waiting for lock, the output is parked low, and the active configuration then follows the inputs on every cycle so that the block cannot stay stuck in that state.

Top module: `tsout_clkgen`

## Requirements
- R1: The source is picked by the code {div_sel_i, sym_off_i}: 2'b00 selects symbol-rate strobes, 2'b01 selects decimation strobes, 2'b10 selects the reference divider and 2'b11 selects the external clock.
- R2: In symbol-rate mode with sym_lock_i high, oclk_o inverts on the clock edge that samples sym_stb_i high. It holds its value on every other edge, and dec_stb_i has no effect.
- R3: In symbol-rate mode, an edge that samples sym_lock_i low drives oclk_o low, and sym_stb_i is ignored. On each such edge the active configuration is reloaded from the inputs.
- R4: In decimation mode, oclk_o inverts on each edge that samples dec_stb_i high, whatever the state of sym_lock_i. sym_stb_i has no effect.
- R5: In divider mode with N = ratio_i + 6, where ratio_i is 3 bits (0 to 7), oclk_o is low for N - floor(N/2) reference cycles and then high for floor(N/2) cycles, and this repeats.
- R6: In external mode, oclk_o equals the value that ext_clk_i had three reference clock edges earlier: two synchronizer flops followed by the output register.
- R7: A change of mode bits or ratio takes effect only on the edge where oclk_o falls, or on an edge covered by R3. Between those edges, a change to the inputs does not alter the output pattern.
- R8: oclk_en_o is high for exactly the first cycle of each high phase of oclk_o and is low at all other times.
- R9: While rst is high, each edge drives oclk_o and oclk_en_o low, restarts the divider from the start of its low phase, clears the synchronizer and loads the active configuration from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel_i | input | 1 | Upper mode bit (manual divider / external) |
| sym_off_i | input | 1 | Lower mode bit (disable symbol-rate source) |
| ratio_i | input | RATIO_W | Divider field; divisor is this value plus DIV_OFFSET |
| sym_lock_i | input | 1 | Symbol lock flag |
| sym_stb_i | input | 1 | Symbol-rate strobe |
| dec_stb_i | input | 1 | Decimation-ratio strobe |
| ext_clk_i | input | 1 | External clock, asynchronous |
| oclk_o | output | 1 | Generated output clock level |
| oclk_en_o | output | 1 | One-cycle pulse on each rising edge of oclk_o |

## Verification
The divider is measured directly at the smallest and largest ratio. The two cases separate the odd-divisor split of the low and high phases from the even one. Directed runs in symbol-rate mode switch lock on and off under continuous strobes, which shows the difference between toggling, parking low and the immediate reload. A directed external run checks the three-edge latency. A long seeded random run then changes the mode bits, the ratio, the lock, both strobes and the external clock at random, and compares every cycle against a reference model kept in the bench. Changes that land in the middle of a half period show whether the reload waits for the falling edge.

// File: rtl/tsout_clkgen_pkg.sv
package tsout_clkgen_pkg;

   typedef enum logic [1:0] {
      SRC_SYM = 2'b00,
      SRC_DEC = 2'b01,
      SRC_DIV = 2'b10,
      SRC_EXT = 2'b11
   } src_e;

endpackage

// File: rtl/tsout_clkgen_sync.sv
module tsout_clkgen_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tsout_clkgen_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[0] <= 1'b0;
            else     chain[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tsout_clkgen_divider.sv
module tsout_clkgen_divider #(
   parameter int RATIO_W    = 3,
   parameter int DIV_OFFSET = 6
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               run_i,
   input  logic               lvl_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               nxt_o
);
   localparam int MAX_DIV = (1 << RATIO_W) - 1 + DIV_OFFSET;
   localparam int CNT_W   = $clog2(MAX_DIV + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] div_n;
   logic [CNT_W-1:0] hi_len;
   logic [CNT_W-1:0] lo_len;
   logic             phase_end;

   always_comb begin
      div_n     = CNT_W'(ratio_i) + CNT_W'(DIV_OFFSET);
      hi_len    = div_n >> 1;
      lo_len    = div_n - hi_len;
      phase_end = lvl_i ? (cnt == hi_len - 1'b1) : (cnt == lo_len - 1'b1);
      nxt_o     = phase_end ? ~lvl_i : lvl_i;
   end

   always_ff @(posedge clk) begin
      if (rst || !run_i)  cnt <= '0;
      else if (phase_end) cnt <= '0;
      else                cnt <= cnt + 1'b1;
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
      run_i |-> (cnt < (lvl_i ? hi_len : lo_len))); // R5
endmodule

// File: rtl/tsout_clkgen_src_sel.sv
module tsout_clkgen_src_sel
   import tsout_clkgen_pkg::*;
(
   input  src_e mode_i,
   input  logic lvl_i,
   input  logic sym_lock_i,
   input  logic sym_stb_i,
   input  logic dec_stb_i,
   input  logic div_nxt_i,
   input  logic ext_sync_i,
   output logic nxt_o,
   output logic park_o
);
   always_comb begin
      park_o = 1'b0;
      unique case (mode_i)
         SRC_SYM: begin
            park_o = ~sym_lock_i;
            nxt_o  = sym_lock_i & (lvl_i ^ sym_stb_i);
         end
         SRC_DEC: nxt_o = lvl_i ^ dec_stb_i;
         SRC_DIV: nxt_o = div_nxt_i;
         default: nxt_o = ext_sync_i;
      endcase
   end
endmodule

// File: rtl/tsout_clkgen.sv
module tsout_clkgen
   import tsout_clkgen_pkg::*;
#(
   parameter int RATIO_W     = 3,
   parameter int DIV_OFFSET  = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               div_sel_i,
   input  logic               sym_off_i,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic               sym_lock_i,
   input  logic               sym_stb_i,
   input  logic               dec_stb_i,
   input  logic               ext_clk_i,
   output logic               oclk_o,
   output logic               oclk_en_o
);
   if (RATIO_W < 1 || RATIO_W > 8) begin : g_bad_ratio_w
      $error("tsout_clkgen: RATIO_W out of range 1..8");
   end
   if (DIV_OFFSET < 2) begin : g_bad_offset
      $error("tsout_clkgen: DIV_OFFSET must be at least 2");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("tsout_clkgen: SYNC_STAGES out of range 2..4");
   end

   src_e               req_mode;
   src_e               act_mode;
   logic [RATIO_W-1:0] act_ratio;
   logic               oclk_q;
   logic               en_q;
   logic               nxt_lvl;
   logic               park;
   logic               div_nxt;
   logic               ext_sync;
   logic               reload;

   assign req_mode = src_e'({div_sel_i, sym_off_i});

   tsout_clkgen_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (ext_clk_i),
      .q_o (ext_sync)
   );

   tsout_clkgen_divider #(
      .RATIO_W    (RATIO_W),
      .DIV_OFFSET (DIV_OFFSET)
   ) u_div (
      .clk     (clk),
      .rst     (rst),
      .run_i   (act_mode == SRC_DIV),
      .lvl_i   (oclk_q),
      .ratio_i (act_ratio),
      .nxt_o   (div_nxt)
   );

   tsout_clkgen_src_sel u_sel (
      .mode_i     (act_mode),
      .lvl_i      (oclk_q),
      .sym_lock_i (sym_lock_i),
      .sym_stb_i  (sym_stb_i),
      .dec_stb_i  (dec_stb_i),
      .div_nxt_i  (div_nxt),
      .ext_sync_i (ext_sync),
      .nxt_o      (nxt_lvl),
      .park_o     (park)
   );

   assign reload = (oclk_q & ~nxt_lvl) | park;

   always_ff @(posedge clk) begin
      if (rst) begin
         oclk_q    <= 1'b0;
         en_q      <= 1'b0;
         act_mode  <= req_mode;
         act_ratio <= ratio_i;
      end else begin
         oclk_q <= nxt_lvl;
         en_q   <= nxt_lvl & ~oclk_q;
         if (reload) begin
            act_mode  <= req_mode;
            act_ratio <= ratio_i;
         end
      end
   end

   assign oclk_o    = oclk_q;
   assign oclk_en_o = en_q;

   AST_RST_STATE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!oclk_q && !en_q)); // R9
   AST_LOCK_PARK: assert property (@(posedge clk) disable iff (rst)
      (act_mode == SRC_SYM && !sym_lock_i) |=> !oclk_q); // R3
   AST_DEC_TOGGLE: assert property (@(posedge clk) disable iff (rst)
      (act_mode == SRC_DEC && dec_stb_i) |=> (oclk_q != $past(oclk_q))); // R4
   AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      (act_mode == SRC_EXT) |=> (oclk_q == $past(ext_sync))); // R6
   AST_CFG_AT_FALL: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && (!$stable(act_mode) || !$stable(act_ratio)))
         |-> ($fell(oclk_q) || $past(park))); // R7
   AST_EN_RISE: assert property (@(posedge clk) disable iff (rst)
      en_q |-> (oclk_q && !$past(oclk_q))); // R8
endmodule

// File: tb/tsout_clkgen_tb.sv
module tsout_clkgen_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       div_sel = 1'b0;
   logic       sym_off = 1'b0;
   logic [2:0] ratio = 3'd0;
   logic       lock = 1'b0;
   logic       sym_stb = 1'b0;
   logic       dec_stb = 1'b0;
   logic       ext_clk = 1'b0;
   logic       oclk;
   logic       oclk_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   tsout_clkgen u_dut (
      .clk        (clk),
      .rst        (rst),
      .div_sel_i  (div_sel),
      .sym_off_i  (sym_off),
      .ratio_i    (ratio),
      .sym_lock_i (lock),
      .sym_stb_i  (sym_stb),
      .dec_stb_i  (dec_stb),
      .ext_clk_i  (ext_clk),
      .oclk_o     (oclk),
      .oclk_en_o  (oclk_en)
   );

   function automatic int div_hi(input int r);
      return (r + 6) / 2;
   endfunction

   function automatic int div_lo(input int r);
      return (r + 6) - div_hi(r);
   endfunction

   // reference model, written from the requirements
   logic [1:0] m_mode = 2'b00;
   int         m_ratio = 0;
   logic       m_oclk = 1'b0;
   logic       m_en = 1'b0;
   int         m_cnt = 0;
   logic       m_s1 = 1'b0;
   logic       m_s2 = 1'b0;

   always @(posedge clk) begin
      logic nx;
      logic park;
      cyc++;
      if (rst) begin
         m_oclk = 1'b0; m_en = 1'b0; m_cnt = 0; m_s1 = 1'b0; m_s2 = 1'b0;
         m_mode = {div_sel, sym_off}; m_ratio = int'(ratio);
      end else begin
         park = 1'b0;
         case (m_mode)
            2'b00: begin park = !lock; nx = lock ? (m_oclk ^ sym_stb) : 1'b0; end
            2'b01: nx = m_oclk ^ dec_stb;
            2'b10: nx = ((m_cnt + 1) == (m_oclk ? div_hi(m_ratio) : div_lo(m_ratio))) ? !m_oclk : m_oclk;
            default: nx = m_s2;
         endcase
         if (m_mode == 2'b10) m_cnt = (nx != m_oclk) ? 0 : m_cnt + 1;
         else                 m_cnt = 0;
         m_en = nx & !m_oclk;
         if ((m_oclk && !nx) || park) begin
            m_mode = {div_sel, sym_off}; m_ratio = int'(ratio);
         end
         m_oclk = nx;
         m_s2 = m_s1;
         m_s1 = ext_clk;
      end
   end

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog: cycle %0d actual running expected finished", cyc);
         summary();
      end
   end

   task automatic check_val(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic tick(input string tag);
      @(negedge clk);
      check_val({tag, " oclk"}, int'(oclk), int'(m_oclk));
      check_val("R8 oclk_en", int'(oclk_en), int'(m_en));
   endtask

   task automatic do_reset(input logic [1:0] md, input logic [2:0] r);
      rst = 1'b1; {div_sel, sym_off} = md; ratio = r;
      tick("R9"); tick("R9");
      check_val("R9 reset oclk", int'(oclk), 0);
      check_val("R9 reset en", int'(oclk_en), 0);
      rst = 1'b0;
   endtask

   task automatic measure_div(input logic [2:0] r);
      int hi;
      int lo;
      int guard;
      do_reset(2'b10, r);
      guard = 0;
      while (!oclk && guard < 40) begin guard++; tick("R5"); end
      hi = 0;
      while (oclk && hi < 40) begin hi++; tick("R5"); end
      lo = 0;
      while (!oclk && lo < 40) begin lo++; tick("R5"); end
      check_val("R5 high length", hi, div_hi(int'(r)));
      check_val("R5 low length", lo, div_lo(int'(r)));
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      tick("R9");
      do_reset(2'b10, 3'd0);

      // R5: divider at both ends of the ratio field
      measure_div(3'd0);
      measure_div(3'd7);
      measure_div(3'd3);

      // R2: symbol-rate strobes with lock
      do_reset(2'b00, 3'd0);
      lock = 1'b1;
      for (int i = 0; i < 40; i++) begin
         sym_stb = (i % 3 == 0); dec_stb = (i % 2 == 0);
         tick("R2");
      end
      // R3: lock lost, strobes keep coming; mode change taken at once
      lock = 1'b0;
      for (int i = 0; i < 10; i++) begin sym_stb = 1'b1; tick("R3"); end
      {div_sel, sym_off} = 2'b01; sym_stb = 1'b0;
      tick("R3");
      // R4: decimation source ignores lock and symbol strobes
      for (int i = 0; i < 30; i++) begin
         dec_stb = (i % 4 != 1); sym_stb = 1'b1; lock = i[0];
         tick("R4");
      end
      dec_stb = 1'b0;

      // R6: external clock latency
      do_reset(2'b11, 3'd0);
      for (int i = 0; i < 40; i++) begin
         ext_clk = (i % 7) < 3;
         tick("R6");
      end

      // R7: ratio change in the middle of a high phase of the divider
      do_reset(2'b10, 3'd7);
      while (!oclk) tick("R7");
      tick("R7");
      ratio = 3'd0;
      for (int i = 0; i < 30; i++) tick("R7");

      // R1 and R7: seeded random mix of all inputs
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 39) == 0) {div_sel, sym_off} = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 29) == 0) ratio = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 59) == 0) lock = ~lock;
         sym_stb = ($urandom_range(0, 2) == 0);
         dec_stb = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 4) == 0) ext_clk = ~ext_clk;
         tick("R1 R7");
      end
      summary();
   end
endmodule